// File: doc/BRIEF.md
# DMA Page and Address Assembly

This block forms the 20-bit memory address used during DMA transfers. The four most significant bits come from a small set of page registers that the CPU loads through I/O writes. The middle byte (A8 to A15) is taken from the DMA controller's data pins, which carry that byte while the controller's address strobe is high; the block captures it and holds it after the strobe falls. The low byte (A0 to A7) is passed straight through from the controller's address pins.

The page register used for a cycle depends on the active channel number. Channel 2 and channel 3 each have their own page register. Channels 0 and 1 share a third one. One port in the decoded range is recognised but stores nothing. The assembled address reaches the bus only while the controller's address-enable input is high. At all other times the address is released: `addr_oe_o` drops low and `addr_o` reads all zeros in place of high impedance.

Top module: `dma_page_addr`

## Requirements
- R1: A page register write stores only `io_wdata_i[3:0]`. Bit n of the stored value drives `addr_o[16+n]`, and data bits 7 to 4 have no effect.
- R2: A write to port 0x80 changes none of the page values seen on any channel.
- R3: A write to port 0x81 sets the page for channel 2 (`dma_chan_i` = 2), and a write to port 0x82 sets the page for channel 3 (`dma_chan_i` = 3). Neither write changes the other channels' pages.
- R4: A write to port 0x83 sets one page value, and channel 0 and channel 1 both use it.
- R5: On every clock edge at which `adstb_i` is high, the middle address byte takes the value of `dma_db_i`. While `adstb_i` is low it keeps the last byte captured.
- R6: While `aen_i` is high, `addr_oe_o` is 1 and `addr_o` equals {page of the selected channel, captured middle byte, `dma_lo_i`}.
- R7: While `aen_i` is low, `addr_oe_o` is 0 and `addr_o` is all zeros.
- R8: After reset, all page values and the middle byte are zero.
- R9: A page write that hits the selected channel's register in the same cycle as an enabled DMA cycle shows up on `addr_o[19:16]` in that cycle (the write takes precedence).
- R10: Writes to ports outside 0x80 to 0x83 change no page value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | CPU I/O port address |
| io_wdata_i | input | 8 | CPU write data |
| io_we_i | input | 1 | CPU I/O write strobe, one cycle per write |
| dma_chan_i | input | 2 | Channel number of the active DMA transfer |
| dma_lo_i | input | 8 | Low address byte from the DMA controller |
| dma_db_i | input | 8 | Multiplexed data/middle-address byte from the DMA controller |
| adstb_i | input | 1 | Address strobe; high while `dma_db_i` carries A8 to A15 |
| aen_i | input | 1 | DMA address enable |
| addr_o | output | 20 | Assembled DMA address, zero when released |
| addr_oe_o | output | 1 | Output enable for `addr_o`, low means high impedance |

## Verification
The assertions expect each I/O write to address exactly one port. They also expect `adstb_i` and `dma_db_i` to be stable around the sampling edge, so that the byte captured on the last high edge is the byte the controller meant to present. The bench changes every input on the falling clock edge and holds each write strobe for exactly one cycle. It lowers the strobe only after driving a different byte onto `dma_db_i`, so a hold failure produces a visible wrong value. Each page check selects a channel through `dma_chan_i` with `aen_i` high and compares the whole 20-bit address against a model kept in the bench.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

  // slot 0: decoded, no storage; 1: ch2; 2: ch3; 3: ch0/ch1
  localparam int unsigned N_SLOT = 4;
  localparam int unsigned SLOT_W = $clog2(N_SLOT);

  typedef logic [1:0] chan_t;
  typedef logic [SLOT_W-1:0] slot_t;

  function automatic slot_t slot_of_chan(chan_t ch);
    unique case (ch)
      2'd2:    return slot_t'(1);
      2'd3:    return slot_t'(2);
      default: return slot_t'(3);
    endcase
  endfunction

endpackage

// File: rtl/dma_page_regs.sv
module dma_page_regs
  import dma_page_pkg::*;
#(
  parameter int unsigned IO_AW     = 8,
  parameter int unsigned PAGE_W    = 4,
  parameter logic [IO_AW-1:0] PORT_BASE = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [PAGE_W-1:0] io_wpage_i,
  input  logic              io_we_i,
  input  slot_t             rd_slot_i,
  output logic [PAGE_W-1:0] rd_page_o
);

  logic [N_SLOT-1:0] dec_hit;
  logic [PAGE_W-1:0] pg_q [N_SLOT];
  logic [(N_SLOT-1)*PAGE_W-1:0] pg_flat;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_dec
    assign dec_hit[g] = io_we_i && (io_addr_i == PORT_BASE + IO_AW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SLOT; s++) pg_q[s] <= '0;
    end else begin
      for (int s = 1; s < N_SLOT; s++)
        if (dec_hit[s]) pg_q[s] <= io_wpage_i;
    end
  end

  for (genvar g = 1; g < N_SLOT; g++) begin : g_flat
    assign pg_flat[(g-1)*PAGE_W +: PAGE_W] = pg_q[g];
  end

  // write-first: a same-cycle write to the selected slot bypasses the register
  always_comb begin
    rd_page_o = pg_q[rd_slot_i];
    if (rd_slot_i != '0 && dec_hit[rd_slot_i]) rd_page_o = io_wpage_i;
  end

  // R2
  base_port_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hit[0] |=> $stable(pg_flat));

  // R10
  foreign_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && dec_hit == '0) |=> $stable(pg_flat));

  // R1
  page_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hit[N_SLOT-1] |=> pg_q[N_SLOT-1] == $past(io_wpage_i));

  // R9
  write_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_slot_i != '0 && dec_hit[rd_slot_i]) |=> pg_q[$past(rd_slot_i)] == $past(rd_page_o));

endmodule

// File: rtl/dma_mid_latch.sv
module dma_mid_latch #(
  parameter int unsigned MID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MID_W-1:0] db_i,
  input  logic             stb_i,
  output logic [MID_W-1:0] mid_o
);

  logic [MID_W-1:0] mid_q;

  // follows db while strobe high, freezes once it falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mid_q <= '0;
    else if (stb_i) mid_q <= db_i;
  end

  assign mid_o = mid_q;

  // R5
  mid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(mid_o));

  // R5
  mid_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> mid_o == $past(db_i));

endmodule

// File: rtl/dma_addr_mux.sv
module dma_addr_mux #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned MID_W  = 8,
  parameter int unsigned LO_W   = 8,
  localparam int unsigned ADDR_W = PAGE_W + MID_W + LO_W
) (
  input  logic              en_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [LO_W-1:0]   lo_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              oe_o
);

  always_comb begin
    oe_o   = en_i;
    addr_o = en_i ? {page_i, mid_i, lo_i} : '0;
  end

endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
  import dma_page_pkg::*;
#(
  parameter int unsigned IO_AW  = 8,
  parameter int unsigned DW     = 8,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned MID_W  = 8,
  parameter int unsigned LO_W   = 8,
  parameter logic [IO_AW-1:0] PORT_BASE = 8'h80,
  localparam int unsigned ADDR_W = PAGE_W + MID_W + LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [DW-1:0]     io_wdata_i,
  input  logic              io_we_i,
  input  logic [1:0]        dma_chan_i,
  input  logic [LO_W-1:0]   dma_lo_i,
  input  logic [MID_W-1:0]  dma_db_i,
  input  logic              adstb_i,
  input  logic              aen_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o
);

  logic [PAGE_W-1:0] sel_page;
  logic [MID_W-1:0]  mid_byte;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^io_wdata_i[DW-1:PAGE_W];

  dma_page_regs #(
    .IO_AW(IO_AW), .PAGE_W(PAGE_W), .PORT_BASE(PORT_BASE)
  ) u_regs (
    .clk_i, .rst_ni,
    .io_addr_i,
    .io_wpage_i(io_wdata_i[PAGE_W-1:0]),
    .io_we_i,
    .rd_slot_i(slot_of_chan(dma_chan_i)),
    .rd_page_o(sel_page)
  );

  dma_mid_latch #(.MID_W(MID_W)) u_mid (
    .clk_i, .rst_ni,
    .db_i(dma_db_i),
    .stb_i(adstb_i),
    .mid_o(mid_byte)
  );

  dma_addr_mux #(.PAGE_W(PAGE_W), .MID_W(MID_W), .LO_W(LO_W)) u_mux (
    .en_i(aen_i),
    .page_i(sel_page),
    .mid_i(mid_byte),
    .lo_i(dma_lo_i),
    .addr_o,
    .oe_o(addr_oe_o)
  );

  // R7
  released_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aen_i |-> (addr_o == '0 && !addr_oe_o));

  // R6
  lo_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> (addr_oe_o && addr_o[LO_W-1:0] == dma_lo_i));

  // R6
  mid_on_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aen_i && $past(adstb_i)) |-> addr_o[LO_W +: MID_W] == $past(dma_db_i));

endmodule

// File: tb/dma_page_addr_bench.sv
module dma_page_addr_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_we = 1'b0;
  logic [1:0]  dma_chan = '0;
  logic [7:0]  dma_lo = '0;
  logic [7:0]  dma_db = '0;
  logic        adstb = 1'b0;
  logic        aen = 1'b0;
  logic [19:0] addr;
  logic        addr_oe;

  int n_chk = 0;
  int n_bad = 0;

  // model: page per channel, middle byte
  logic [3:0] m_pg [4];
  logic [7:0] m_mid;

  always #4 clk = ~clk;

  dma_page_addr u_dma_page_addr (
    .clk_i(clk), .rst_ni,
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_we_i(io_we),
    .dma_chan_i(dma_chan), .dma_lo_i(dma_lo), .dma_db_i(dma_db),
    .adstb_i(adstb), .aen_i(aen),
    .addr_o(addr), .addr_oe_o(addr_oe)
  );

  task automatic chk(string req, logic [20:0] act, logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] port, logic [7:0] data);
    @(negedge clk);
    io_addr = port; io_wdata = data; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0;
    unique case (port)
      8'h81: m_pg[2] = data[3:0];
      8'h82: m_pg[3] = data[3:0];
      8'h83: begin m_pg[0] = data[3:0]; m_pg[1] = data[3:0]; end
      default: ;
    endcase
  endtask

  // drive channel with aen high and compare full address + oe
  task automatic probe(string req, logic [1:0] ch, logic [7:0] lo);
    @(negedge clk);
    aen = 1'b1; dma_chan = ch; dma_lo = lo;
    #1;
    chk(req, {addr_oe, addr}, {1'b1, m_pg[ch], m_mid, lo});
  endtask

  task automatic t_reset;
    for (int c = 0; c < 4; c++) probe("R8", 2'(c), 8'h00);
  endtask

  task automatic t_pages;
    io_write(8'h81, 8'hA5);                // R1: upper nibble dropped
    probe("R1", 2'd2, 8'h11);
    chk("R1", {1'b0, addr[19:16], 16'h0}, {1'b0, 4'h5, 16'h0});
    io_write(8'h82, 8'h97);
    probe("R3", 2'd3, 8'h22);
    probe("R3", 2'd2, 8'h23);
    io_write(8'h83, 8'h3C);
    probe("R4", 2'd0, 8'h33);
    probe("R4", 2'd1, 8'h34);
    probe("R3", 2'd3, 8'h35);
  endtask

  task automatic t_base_port;
    io_write(8'h80, 8'hFF);
    for (int c = 0; c < 4; c++) probe("R2", 2'(c), 8'h40);
  endtask

  task automatic t_foreign;
    io_write(8'h84, 8'hFF);
    io_write(8'h7F, 8'hEE);
    io_write(8'h03, 8'hDD);
    for (int c = 0; c < 4; c++) probe("R10", 2'(c), 8'h50);
  endtask

  task automatic t_mid;
    @(negedge clk);
    adstb = 1'b1; dma_db = 8'h6B;
    @(negedge clk);
    m_mid = 8'h6B;
    probe("R5", 2'd2, 8'h61);
    dma_db = 8'hC4;                         // still high: tracks
    @(negedge clk);
    m_mid = 8'hC4;
    adstb = 1'b0; dma_db = 8'h0F;           // falls: must hold C4
    @(negedge clk);
    dma_db = 8'hF0;
    @(negedge clk);
    probe("R5", 2'd0, 8'h62);
    probe("R6", 2'd3, 8'hFE);
  endtask

  task automatic t_aen_low;
    @(negedge clk);
    aen = 1'b0; dma_chan = 2'd3; dma_lo = 8'hFF;
    #1;
    chk("R7", {addr_oe, addr}, 21'h0);
    aen = 1'b0; dma_chan = 2'd0; dma_lo = 8'h5A;
    #1;
    chk("R7", {addr_oe, addr}, 21'h0);
  endtask

  task automatic t_write_first;
    @(negedge clk);
    aen = 1'b1; dma_chan = 2'd3; dma_lo = 8'h77;
    io_addr = 8'h82; io_wdata = 8'h0E; io_we = 1'b1;
    #1;
    chk("R9", {addr_oe, addr}, {1'b1, 4'hE, m_mid, 8'h77});
    @(negedge clk);
    io_we = 1'b0;
    m_pg[3] = 4'hE;
    probe("R9", 2'd3, 8'h78);
    // write to a different slot must not bypass
    @(negedge clk);
    dma_chan = 2'd1; io_addr = 8'h81; io_wdata = 8'h09; io_we = 1'b1;
    #1;
    chk("R9", {addr_oe, addr}, {1'b1, m_pg[1], m_mid, dma_lo});
    @(negedge clk);
    io_we = 1'b0;
    m_pg[2] = 4'h9;
    probe("R3", 2'd2, 8'h79);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) m_pg[c] = '0;
    m_mid = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_pages();
    t_base_port();
    t_foreign();
    t_mid();
    t_aen_low();
    t_write_first();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule